// File: doc/BRIEF.md
# Programmable External Interrupt Edge Detector

The block watches eight asynchronous interrupt pins and turns a chosen kind of transition on each pin into a request pulse one clock wide. Every pin first passes through a synchronizer. The synchronized level is then compared with the level seen one clock earlier. A flop holding that earlier level always follows the pin, even while detection is off for that pin.

Two 8-bit enable registers set the mode of each channel. One register holds the rising-edge enables and the other holds the falling-edge enables. Bit n of each register belongs to channel n. Software reaches the registers through a plain register bus. A write can replace a whole byte or change one addressed bit, and a read returns a whole byte. Before a pin is handed to another function, software must clear both of its enable bits, because a level change on the pin can still be seen as an edge.

Top module: `irq_edge_unit`

## Requirements
- R1: After reset both enable registers read 00H and no request is raised.
- R2: A byte write (bit_mode_i=0) to address FF48H loads the rising-enable register and one to FF49H loads the falling-enable register. Each register reads back at its own address.
- R3: A bit write (bit_mode_i=1) copies wdata_i[0] into bit bit_idx_i of the addressed register and leaves the other seven bits unchanged.
- R4: A read of any other address returns 00H, and a write to any other address changes neither register.
- R5: The mode of channel n is set by (rise bit n, fall bit n). 00 detects nothing, 01 detects falling edges only, 10 detects rising edges only and 11 detects both.
- R6: Each enabled edge gives exactly one pulse, one clock wide. The pulse is high after the third rising clock edge that follows the pin change.
- R7: Channels work independently, so several channels can pulse in the same cycle.
- R8: If a write changes an enable in the same cycle in which an edge is judged, the edge is judged by the value the enable had before the write.
- R9: Turning on detection while a pin rests at a steady level raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 8 | Asynchronous interrupt pins |
| addr_i | input | 16 | Register address |
| wr_i | input | 1 | Write strobe |
| bit_mode_i | input | 1 | 1 selects a single-bit write, 0 a byte write |
| bit_idx_i | input | 3 | Bit index for a single-bit write |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| irq_o | output | 8 | Request pulses, one per channel |

## Verification
The bench builds the block with its default values: eight channels, a 16-bit address and two synchronizer stages. With these values all four modes can be swept over every channel and both edge directions, and the pulse is checked against the exact cycle predicted by the three-register latency. Every bit index is tried with both bit values, and mixed per-channel modes are applied with all pins switching at once. Directed cases also cover the write that coincides with edge evaluation and enabling a channel while its pin is held high.

// File: rtl/irq_edge_pkg.sv
package irq_edge_pkg;
  localparam int unsigned DEF_ADDR_W   = 16;
  localparam logic [15:0] DEF_RISE_ADR = 16'hFF48;
  localparam logic [15:0] DEF_FALL_ADR = 16'hFF49;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_RISE = 2'd1,
    SEL_FALL = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/irq_edge_cfg.sv
module irq_edge_cfg
  import irq_edge_pkg::*;
#(
  parameter int unsigned          NUM_CH   = 8,
  parameter int unsigned          ADDR_W   = DEF_ADDR_W,
  parameter logic [ADDR_W-1:0]    RISE_ADR = DEF_RISE_ADR[ADDR_W-1:0],
  parameter logic [ADDR_W-1:0]    FALL_ADR = DEF_FALL_ADR[ADDR_W-1:0],
  localparam int unsigned         IDX_W    = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              bit_mode_i,
  input  logic [IDX_W-1:0]  bit_idx_i,
  input  logic [NUM_CH-1:0] wdata_i,
  output logic [NUM_CH-1:0] rdata_o,
  output logic [NUM_CH-1:0] rise_en_o,
  output logic [NUM_CH-1:0] fall_en_o
);
  reg_sel_e          sel;
  logic [NUM_CH-1:0] rise_q, fall_q;
  logic [NUM_CH-1:0] cur, nxt;

  always_comb begin
    if (addr_i == RISE_ADR)      sel = SEL_RISE;
    else if (addr_i == FALL_ADR) sel = SEL_FALL;
    else                         sel = SEL_NONE;
  end

  always_comb begin
    case (sel)
      SEL_RISE: cur = rise_q;
      SEL_FALL: cur = fall_q;
      default:  cur = '0;
    endcase
  end

  // bit mode merges one bit into current contents
  always_comb begin
    nxt = wdata_i;
    if (bit_mode_i) begin
      nxt = cur;
      nxt[bit_idx_i] = wdata_i[0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_q <= '0;
      fall_q <= '0;
    end else if (wr_i) begin
      if (sel == SEL_RISE) rise_q <= nxt;
      if (sel == SEL_FALL) fall_q <= nxt;
    end
  end

  assign rdata_o   = cur;
  assign rise_en_o = rise_q;
  assign fall_en_o = fall_q;

  p_byte_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !bit_mode_i && sel == SEL_FALL) |=> fall_q == $past(wdata_i));

  p_bit_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && bit_mode_i && sel == SEL_RISE) |=> rise_q[$past(bit_idx_i)] == $past(wdata_i[0]));

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && sel != SEL_NONE) |=> ($stable(rise_q) && $stable(fall_q)));
endmodule

// File: rtl/irq_edge_core.sv
module irq_edge_core #(
  parameter int unsigned NUM_CH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] sync_i,
  input  logic [NUM_CH-1:0] rise_en_i,
  input  logic [NUM_CH-1:0] fall_en_i,
  output logic [NUM_CH-1:0] irq_o
);
  logic [NUM_CH-1:0] prev_q, irq_q;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic is_rise, is_fall;
    assign is_rise = sync_i[i] & ~prev_q[i];
    assign is_fall = ~sync_i[i] & prev_q[i];

    // history follows the pin regardless of enables
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q[i] <= 1'b0;
        irq_q[i]  <= 1'b0;
      end else begin
        prev_q[i] <= sync_i[i];
        irq_q[i]  <= (is_rise & rise_en_i[i]) | (is_fall & fall_en_i[i]);
      end
    end

    p_rise_only_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_q[i] && !$past(fall_en_i[i])) |-> $past(sync_i[i]));

    p_fall_only_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_q[i] && !$past(rise_en_i[i])) |-> !$past(sync_i[i]));

    p_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(rise_en_i[i] || fall_en_i[i]) |=> !irq_q[i]);

    p_needs_change_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_q[i] |-> ($past(sync_i[i]) != $past(sync_i[i], 2)));
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_edge_unit.sv
module irq_edge_unit
  import irq_edge_pkg::*;
#(
  parameter int unsigned       NUM_CH      = 8,
  parameter int unsigned       ADDR_W      = DEF_ADDR_W,
  parameter int unsigned       SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] RISE_ADR    = DEF_RISE_ADR[ADDR_W-1:0],
  parameter logic [ADDR_W-1:0] FALL_ADR    = DEF_FALL_ADR[ADDR_W-1:0],
  localparam int unsigned      IDX_W       = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] pin_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              bit_mode_i,
  input  logic [IDX_W-1:0]  bit_idx_i,
  input  logic [NUM_CH-1:0] wdata_i,
  output logic [NUM_CH-1:0] rdata_o,
  output logic [NUM_CH-1:0] irq_o
);
  logic [NUM_CH-1:0] pin_sync, rise_en, fall_en;

  irq_sync #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  irq_edge_cfg #(
    .NUM_CH  (NUM_CH),
    .ADDR_W  (ADDR_W),
    .RISE_ADR(RISE_ADR),
    .FALL_ADR(FALL_ADR)
  ) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .wr_i      (wr_i),
    .bit_mode_i(bit_mode_i),
    .bit_idx_i (bit_idx_i),
    .wdata_i   (wdata_i),
    .rdata_o   (rdata_o),
    .rise_en_o (rise_en),
    .fall_en_o (fall_en)
  );

  irq_edge_core #(.NUM_CH(NUM_CH)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sync_i   (pin_sync),
    .rise_en_i(rise_en),
    .fall_en_i(fall_en),
    .irq_o    (irq_o)
  );

  p_reset_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> irq_o == '0);
endmodule

// File: tb/irq_edge_unit_tb.sv
module irq_edge_unit_tb;
  localparam logic [15:0] A_RISE = 16'hFF48;
  localparam logic [15:0] A_FALL = 16'hFF49;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pin = '0;
  logic [15:0] addr = '0;
  logic       wr = 1'b0;
  logic       bmode = 1'b0;
  logic [2:0] bidx = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_edge_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .addr_i(addr), .wr_i(wr),
    .bit_mode_i(bmode), .bit_idx_i(bidx), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; bmode = 1'b0; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic wr_bit(input logic [15:0] a, input logic [2:0] i, input logic v);
    @(negedge clk); addr = a; wdata = {7'd0, v}; bidx = i; bmode = 1'b1; wr = 1'b1;
    @(negedge clk); wr = 1'b0; bmode = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  // apply new pin vector, expect vector exp only at the 3rd negedge after
  task automatic pin_step(input logic [7:0] nv, input logic [7:0] exp, input string req);
    logic [7:0] seen;
    bit ok;
    ok = 1'b1; seen = '0;
    @(negedge clk); pin = nv;
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      if (k == 3) begin seen = irq; if (irq !== exp) ok = 1'b0; end
      else if (irq !== 8'h00) begin seen = irq; ok = 1'b0; end
    end
    chk(ok, req, seen, exp);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'hFF);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [7:0] model;
    repeat (3) @(negedge clk);
    // R1: reset state
    rd(A_RISE, d); chk(d == 8'h00, "R1 rise reset", d, 8'h00);
    rd(A_FALL, d); chk(d == 8'h00, "R1 fall reset", d, 8'h00);
    chk(irq == 8'h00, "R1 irq idle", irq, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); chk(irq == 8'h00, "R1 irq after release", irq, 8'h00);

    // R2: byte access
    wr_byte(A_RISE, 8'h5A); wr_byte(A_FALL, 8'hC3);
    rd(A_RISE, d); chk(d == 8'h5A, "R2 rise byte", d, 8'h5A);
    rd(A_FALL, d); chk(d == 8'hC3, "R2 fall byte", d, 8'hC3);

    // R4: unmapped address
    wr_byte(16'hFF4A, 8'hFF); wr_byte(16'h0048, 8'hFF);
    rd(16'hFF4A, d); chk(d == 8'h00, "R4 unmapped read", d, 8'h00);
    rd(A_RISE, d); chk(d == 8'h5A, "R4 rise untouched", d, 8'h5A);
    rd(A_FALL, d); chk(d == 8'hC3, "R4 fall untouched", d, 8'hC3);

    // R3: bit writes sweep over every index, both values, both registers
    model = 8'h5A;
    for (int i = 0; i < 8; i++) begin
      for (int v = 0; v < 2; v++) begin
        wr_bit(A_RISE, 3'(i), 1'(v));
        model[i] = 1'(v);
        rd(A_RISE, d); chk(d == model, "R3 rise bit", d, model);
      end
    end
    model = 8'hC3;
    for (int i = 0; i < 8; i++) begin
      wr_bit(A_FALL, 3'(i), ~model[i]);
      model[i] = ~model[i];
      rd(A_FALL, d); chk(d == model, "R3 fall bit", d, model);
    end

    // R5/R6: every mode x channel x direction
    for (int m = 0; m < 4; m++) begin
      wr_byte(A_RISE, m[1] ? 8'hFF : 8'h00);
      wr_byte(A_FALL, m[0] ? 8'hFF : 8'h00);
      for (int ch = 0; ch < 8; ch++) begin
        pin_step(pin | (8'h01 << ch), m[1] ? (8'h01 << ch) : 8'h00, "R5 R6 rise");
        pin_step(pin & ~(8'h01 << ch), m[0] ? (8'h01 << ch) : 8'h00, "R5 R6 fall");
      end
    end

    // R7: mixed per-channel modes, all pins switching together
    wr_byte(A_RISE, 8'hA5); wr_byte(A_FALL, 8'h3C);
    pin_step(8'hFF, 8'hA5, "R7 all rise");
    pin_step(8'h00, 8'h3C, "R7 all fall");
    pin_step(8'h0F, 8'h05, "R7 low nibble rise");
    pin_step(8'hF0, 8'hAC, "R7 swap");

    // R8: enable written in the cycle the edge is judged
    wr_byte(A_RISE, 8'h00); wr_byte(A_FALL, 8'h00);
    pin_step(8'h00, 8'h00, "R8 settle");
    @(negedge clk); pin = 8'h01;
    @(negedge clk);
    @(negedge clk); addr = A_RISE; wdata = 8'h01; bmode = 1'b0; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    chk(irq == 8'h00, "R8 old enable used", irq, 8'h00);
    @(negedge clk); chk(irq == 8'h00, "R8 no late pulse", irq, 8'h00);
    pin_step(8'h00, 8'h00, "R8 fall ignored");
    pin_step(8'h01, 8'h01, "R8 new enable used");

    // R9: enabling while pins rest high
    wr_byte(A_RISE, 8'h00);
    pin_step(8'hFF, 8'h00, "R9 pins up disabled");
    wr_byte(A_RISE, 8'hFF); wr_byte(A_FALL, 8'hFF);
    d = 8'h00;
    for (int k = 0; k < 6; k++) begin @(negedge clk); d = d | irq; end
    chk(d == 8'h00, "R9 no pulse on enable", d, 8'h00);
    pin_step(8'hFE, 8'h01, "R9 later edge seen");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule